// File: doc/BRIEF.md
# Systolic Multiply-Accumulate FIR Filter

This block is an eight-tap finite impulse response filter arranged as a chain of identical multiply-accumulate cells. Input samples step through a delay line with two registers per tap, while each cell registers its product and then its running partial sum before passing that sum to the next cell. The first cell begins from zero, and the last cell's sum register drives the output. Every register stage matches one that a dedicated multiply-accumulate slice already contains. The carry path is therefore never longer than one adder, whatever the number of taps.

The block accepts one signed 18-bit sample per cycle in which `in_vld` is high. Nothing inside moves while `in_vld` is low. Coefficients are fixed at elaboration time by a parameter. The result is kept at full precision: 36-bit products are summed into a 39-bit accumulator with no rounding. A pulse on `out_vld` marks each new result once the pipeline has filled.

Top module: `sysfir_top`

## Requirements
- R1: For accepted samples x[0], x[1], ... counted since reset (with x of a negative index taken as 0), the output belonging to y[m] equals the exact sum over k = 0..7 of b_k * x[m-k]. Here b_k is the 18-bit signed field COEF[k], held at bits [18k+17:18k] of the coefficient parameter.
- R2: The value y[m] appears on `out_data` in the cycle after the clock edge that accepts sample m+9. The latency is therefore nine accepted samples, and before the pipeline fills the output shows the same formula with zero history.
- R3: `out_vld` is high for exactly one cycle after each accepted sample, counted from the tenth accepted sample since reset onward. It is low in every other cycle.
- R4: In a cycle with `in_vld` low, `in_data` is ignored, no register advances, `out_data` keeps its value and `out_vld` is low in the following cycle.
- R5: Driving `rst_n` low clears the output, the valid pipeline and all sample and sum history at once. Release takes effect on the second rising clock edge after `rst_n` goes high, and no sample is accepted before that edge.
- R6: Full-scale inputs, including -131072 samples against -131072 coefficients, never overflow. Every result lies within ±8·2^34 and equals the exact sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_vld | input | 1 | Sample strobe and clock enable for all stages |
| in_data | input | 18 | Signed input sample |
| out_vld | output | 1 | One-cycle pulse marking a new filled result |
| out_data | output | 39 | Signed full-precision filter output |

## Verification
The bench builds the filter with the default eight taps and 18-bit samples. It uses a coefficient set of distinct values of both signs that includes -131072, 131071, -131071 and 131070. The distinct values let an impulse expose any misordering or wrong tap delay. The extreme values let full-scale negative inputs drive the accumulator close to its 2^37 limit, which an accumulator narrower than 39 bits cannot hold. Gaps of random length in `in_vld` and a reset in the middle of a stream test the clock enable and the clearing of the history.

// File: rtl/sysfir_pkg.sv
package sysfir_pkg;

  localparam int unsigned TAPS_DEF = 8;
  localparam int unsigned DW_DEF   = 18;
  localparam int unsigned CW_DEF   = 18;

  // b7 .. b0 from left to right; b_k sits at bits [18k+17:18k]
  localparam logic [TAPS_DEF*CW_DEF-1:0] COEF_DEF = {
    18'h1FFFE, 18'h20001, 18'h12FD1, 18'h27961,
    18'h1D4C0, 18'h20430, 18'h1FFFF, 18'h20000
  };

  // accumulator width that holds the sum of taps full-precision products
  function automatic int unsigned acc_width(int unsigned pw, int unsigned taps);
    return pw + $clog2(taps);
  endfunction

endpackage

// File: rtl/sysfir_rst_sync.sv
module sysfir_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/sysfir_tap_delay.sv
module sysfir_tap_delay #(
  parameter int unsigned DW    = 18,
  parameter int unsigned DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout
);

  logic signed [DW-1:0] stg_q [DEPTH];
  logic signed [DW-1:0] stg_d [DEPTH];

  always_comb begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      stg_d[i] = stg_q[i];
    end
    if (en) begin
      stg_d[0] = din;
      for (int i = 1; i < int'(DEPTH); i++) begin
        stg_d[i] = stg_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) begin
        stg_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < int'(DEPTH); i++) begin
        stg_q[i] <= stg_d[i];
      end
    end
  end

  assign dout = stg_q[DEPTH-1];

endmodule

// File: rtl/sysfir_cell.sv
module sysfir_cell #(
  parameter int unsigned DW = 18,
  parameter int unsigned CW = 18,
  parameter int unsigned AW = 39,
  parameter logic signed [CW-1:0] COEF = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] x_in,
  input  logic signed [AW-1:0] sum_in,
  output logic signed [AW-1:0] sum_out
);

  localparam int unsigned PW = DW + CW;

  logic signed [PW-1:0] prod_q;
  logic signed [PW-1:0] prod_d;
  logic signed [AW-1:0] sum_q;
  logic signed [AW-1:0] sum_d;

  // stage 1: product register, stage 2: partial-sum register
  always_comb begin
    prod_d = prod_q;
    sum_d  = sum_q;
    if (en) begin
      prod_d = PW'(x_in) * PW'(COEF);
      sum_d  = sum_in + AW'(prod_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      sum_q  <= '0;
    end else begin
      prod_q <= prod_d;
      sum_q  <= sum_d;
    end
  end

  assign sum_out = sum_q;

endmodule

// File: rtl/sysfir_vld_pipe.sv
module sysfir_vld_pipe #(
  parameter int unsigned LAT = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic vld_out
);

  logic [LAT-1:0] fill_q;
  logic [LAT-1:0] fill_d;
  logic           vld_q;
  logic           vld_d;

  always_comb begin
    fill_d = fill_q;
    vld_d  = 1'b0;
    if (en) begin
      fill_d = {fill_q[LAT-2:0], 1'b1};
      vld_d  = fill_q[LAT-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      fill_q <= fill_d;
      vld_q  <= vld_d;
    end
  end

  assign vld_out = vld_q;

endmodule

// File: rtl/sysfir_top.sv
module sysfir_top
  import sysfir_pkg::*;
#(
  parameter int unsigned TAPS = TAPS_DEF,
  parameter int unsigned DW   = DW_DEF,
  parameter int unsigned CW   = CW_DEF,
  parameter logic [TAPS*CW-1:0] COEF = COEF_DEF,
  localparam int unsigned PW  = DW + CW,
  localparam int unsigned AW  = acc_width(PW, TAPS),
  localparam int unsigned LAT = TAPS + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_vld,
  output logic signed [AW-1:0] out_data
);

  logic                 rst_sync_n;
  logic signed [DW-1:0] x_tap [TAPS];
  logic signed [AW-1:0] psum  [TAPS];

  sysfir_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar k = 0; k < int'(TAPS); k++) begin : g_cell
    if (k == 0) begin : g_head
      sysfir_tap_delay #(.DW(DW), .DEPTH(1)) u_dly (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .en    (in_vld),
        .din   (in_data),
        .dout  (x_tap[k])
      );
      sysfir_cell #(.DW(DW), .CW(CW), .AW(AW), .COEF(COEF[k*CW +: CW])) u_mac (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .en      (in_vld),
        .x_in    (x_tap[k]),
        .sum_in  ('0),
        .sum_out (psum[k])
      );
    end else begin : g_body
      sysfir_tap_delay #(.DW(DW), .DEPTH(2)) u_dly (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .en    (in_vld),
        .din   (x_tap[k-1]),
        .dout  (x_tap[k])
      );
      sysfir_cell #(.DW(DW), .CW(CW), .AW(AW), .COEF(COEF[k*CW +: CW])) u_mac (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .en      (in_vld),
        .x_in    (x_tap[k]),
        .sum_in  (psum[k-1]),
        .sum_out (psum[k])
      );
    end
  end

  sysfir_vld_pipe #(.LAT(LAT)) u_vld (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (in_vld),
    .vld_out (out_vld)
  );

  assign out_data = psum[TAPS-1];

endmodule

// File: rtl/sysfir_chk.sv
module sysfir_chk #(
  parameter int unsigned TAPS = 8,
  parameter int unsigned DW   = 18,
  parameter int unsigned CW   = 18,
  parameter int unsigned AW   = 39,
  parameter int unsigned LAT  = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_vld,
  input logic                 out_vld,
  input logic signed [AW-1:0] out_data
);

  localparam longint BOUND = longint'(TAPS) * (64'sd1 << (DW - 1)) * (64'sd1 << (CW - 1));
  localparam int unsigned CNTW = $clog2(LAT + 2) + 1;

  logic [CNTW-1:0] acc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt <= '0;
    end else if (in_vld && acc_cnt <= CNTW'(LAT)) begin
      acc_cnt <= acc_cnt + 1'b1;
    end
  end

  // R3: a result is flagged only once more than LAT samples were accepted
  a_r3_needs_fill: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> acc_cnt > CNTW'(LAT));

  // R3: each flag follows an accepted sample
  a_r3_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld));

  // R4: an idle cycle freezes the output and raises no flag
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(out_data) && !out_vld));

  // R5: reset clears the output side
  a_r5_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (out_data == '0 && !out_vld));

  // R6: the result stays within the full-precision bound
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (longint'(out_data) <= BOUND) && (longint'(out_data) >= -BOUND));

endmodule

bind sysfir_top sysfir_chk #(
  .TAPS (TAPS),
  .DW   (DW),
  .CW   (CW),
  .AW   (AW),
  .LAT  (LAT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .in_vld   (in_vld),
  .out_vld  (out_vld),
  .out_data (out_data)
);

// File: tb/tb_sysfir_top.sv
module tb_sysfir_top;

  localparam int TAPS = 8;
  localparam int LAT  = 9;
  localparam logic [TAPS*18-1:0] COEF = {
    18'h1FFFE, 18'h20001, 18'h12FD1, 18'h27961,
    18'h1D4C0, 18'h20430, 18'h1FFFF, 18'h20000
  };

  logic               clk;
  logic               rst_n;
  logic               in_vld;
  logic signed [17:0] in_data;
  logic               out_vld;
  logic signed [38:0] out_data;

  int     vecs  = 0;
  int     fails = 0;
  bit     done  = 0;
  longint hist [0:1023];
  int     n_acc = 0;

  sysfir_top #(.COEF(COEF)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_data  (in_data),
    .out_vld  (out_vld),
    .out_data (out_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic longint bk(input int k);
    case (k)
      0: return -131072;
      1: return 131071;
      2: return -130000;
      3: return 120000;
      4: return -99999;
      5: return 77777;
      6: return -131071;
      default: return 131070;
    endcase
  endfunction

  function automatic longint xh(input int i);
    if (i < 0) return 0;
    return hist[i];
  endfunction

  // output after accepting sample index t is y[t-LAT]
  function automatic longint model(input int t);
    longint s = 0;
    for (int j = 0; j < TAPS; j++) s += bk(j) * xh(t - LAT - j);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // starts and ends at a falling edge
  task automatic push(input logic signed [17:0] s, input string req);
    longint e;
    in_vld  = 1'b1;
    in_data = s;
    hist[n_acc] = longint'(s);
    n_acc++;
    @(negedge clk);
    in_vld  = 1'b0;
    in_data = $signed(18'($urandom));
    e = model(n_acc - 1);
    chk(out_data == 39'(e), req, longint'(out_data), e);
    chk(out_vld == (n_acc > LAT), {req, " R3 vld"}, longint'(out_vld), longint'(n_acc > LAT));
  endtask

  task automatic idle(input int g);
    longint held;
    held = longint'(out_data);
    for (int i = 0; i < g; i++) begin
      in_vld  = 1'b0;
      in_data = $signed(18'($urandom));
      @(negedge clk);
      chk(!out_vld, "R4 vld low", longint'(out_vld), 0);
      chk(longint'(out_data) == held, "R4 hold", longint'(out_data), held);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_data == '0, "R5 data clear", longint'(out_data), 0);
    chk(!out_vld, "R5 vld clear", longint'(out_vld), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    n_acc = 0;
  endtask

  task automatic t_impulse();
    push(18'sd32767, "R1 impulse");
    for (int i = 0; i < 20; i++) push(18'sd0, "R2 impulse tail");
  endtask

  task automatic t_step();
    for (int i = 0; i < 20; i++) push(18'sd1000, "R1 step");
  endtask

  task automatic t_random();
    for (int i = 0; i < 80; i++) begin
      push($signed(18'($urandom)), "R1 random");
      if (($urandom % 3) == 0) idle(1 + int'($urandom % 3));
    end
  endtask

  task automatic t_fullscale();
    for (int i = 0; i < 16; i++) push(-18'sd131072, "R6 neg full scale");
    for (int i = 0; i < 32; i++)
      push((bk(7 - (i % 8)) < 0) ? -18'sd131072 : 18'sd131071, "R6 alternating");
  endtask

  task automatic t_midreset();
    for (int i = 0; i < 6; i++) push($signed(18'($urandom)), "R1 pre reset");
    @(negedge clk);
    do_reset();
    push(18'sd5, "R5 fresh history");
    for (int i = 0; i < 12; i++) push(18'sd0, "R5 fresh history");
  endtask

  initial begin
    rst_n   = 1'b1;
    in_vld  = 1'b0;
    in_data = '0;
    void'($urandom(17));
    #1 rst_n = 1'b0;
    @(negedge clk);
    do_reset();
    t_impulse();
    idle(4);
    t_step();
    t_random();
    t_fullscale();
    t_midreset();
    idle(2);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      vecs++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

endmodule